// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic core of an 8-bit accumulator machine. Each cycle it can take one operation: a code, the accumulator value, a second operand, an extra operand used only by multiply and divide, and a single-bit operand. One clock edge later it presents a low result byte, a high result byte and a pulse that marks the result as valid. The same edge updates the three status flags it holds: carry (C), overflow (OV) and auxiliary (nibble) carry (AC).

Each operation changes only its own set of flags and leaves the others as they were. Software can also write the status byte, or one bit of it, directly. A direct write takes priority over the flag update of an operation in the same cycle. Fetch, operand addressing and register banks are outside the block. The surrounding core sends in the operand values and takes away the result bytes.

Top module: `acc_alu_flags`

## Requirements
- R1: Operation codes on `op_sel` are NOP=0, ADD=1, ADDC=2, SUBB=3, MUL=4, DIV=5, DADJ=6, RRC=7, RLC=8, CMP=9, CCLR=10, CSET=11, CINV=12, CMOV=13, CAND=14, CANDN=15, COR=16, CORN=17. Codes 18 to 31 act as NOP. An operation presented with `op_valid` at one rising edge makes `res_valid` high for exactly the following cycle, with that operation's results. Every operation except MUL and DIV gives `res_hi`=0. NOP and the carry-only operations give `res_lo`=accumulator.
- R2: ADD gives acc+opnd and ADDC gives acc+opnd+C, both modulo 256. C is the carry out of bit 7. AC is the carry out of bit 3. OV is set when the carry into bit 7 differs from the carry out of bit 7.
- R3: SUBB gives acc-opnd-C modulo 256. C is the borrow out of bit 7. AC is the borrow out of the low nibble. OV is set when the signed result does not fit in 8 bits.
- R4: MUL puts the 16-bit product acc*breg in `res_hi`:`res_lo`. It clears C. It sets OV exactly when the product exceeds 255.
- R5: DIV with a nonzero `breg_in` gives the quotient in `res_lo` and the remainder in `res_hi`, with OV=0. With `breg_in`=0 it sets OV, and the result bytes carry no meaning. C is cleared in both cases.
- R6: DADJ adds 0x06 when the low nibble exceeds 9 or AC is set. It then adds 0x60 when the high nibble exceeds 9 or C is set. C becomes set if either step carries out, and DADJ never clears C.
- R7: RRC gives {C, acc[7:1]} with new C = acc[0]. RLC gives {acc[6:0], C} with new C = acc[7].
- R8: CMP sets C when acc < opnd, compared as unsigned values, and clears C otherwise.
- R9: For the carry-only operations the new C is: CCLR 0, CSET 1, CINV the inverted C, CMOV the bit operand, CAND C&bit, CANDN C&~bit, COR C|bit, CORN C|~bit.
- R10: Only ADD, ADDC and SUBB change AC. OV is changed only by ADD, ADDC, SUBB, MUL and DIV. NOP and unknown codes change no flag.
- R11: `psw_wr_byte` loads C from `psw_wdata[7]`, AC from bit 6 and OV from bit 2. It overrides both an operation and a bit write in the same cycle.
- R12: `psw_wr_bit` writes `psw_bit_val` into the flag at `psw_bit_sel` (7=C, 6=AC, 2=OV). It overrides the operation's update of that flag only. Any other index changes no flag.
- R13: After reset all flags, `res_valid`, `res_lo` and `res_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| breg_in | input | 8 | Multiplier or divisor |
| bit_in | input | 1 | Single-bit operand for carry logic |
| psw_wr_byte | input | 1 | Write the whole status byte |
| psw_wdata | input | 8 | Status byte write data |
| psw_wr_bit | input | 1 | Write one status bit |
| psw_bit_sel | input | 3 | Bit index for the bit write |
| psw_bit_val | input | 1 | Value for the bit write |
| res_valid | output | 1 | Results valid this cycle |
| res_lo | output | 8 | Low result byte |
| res_hi | output | 8 | High result byte (product high or remainder) |
| flag_c | output | 1 | Carry flag |
| flag_ov | output | 1 | Overflow flag |
| flag_ac | output | 1 | Auxiliary carry flag |

## Verification
The hardest case to reach from the ports is a collision: an operation and a direct status write land on the same edge, and the write covers some flags but not others. The bench drives an ADD together with a bit write to OV. This exposes a mixed result, with C and AC taken from the adder and OV taken from the write. It also drives a byte write and a bit write together with an operation, which shows the byte write winning. DADJ is brought to its carry-holding path by setting C first and then adjusting a value whose nibbles alone would not carry.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int WORD_W = 8;
  localparam int OP_W   = 5;
  localparam int IDX_W  = 3;
  localparam int NIB_W  = WORD_W / 2;
  localparam int PROD_W = 2 * WORD_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 5'd0,
    OP_ADD   = 5'd1,
    OP_ADDC  = 5'd2,
    OP_SUBB  = 5'd3,
    OP_MUL   = 5'd4,
    OP_DIV   = 5'd5,
    OP_DADJ  = 5'd6,
    OP_RRC   = 5'd7,
    OP_RLC   = 5'd8,
    OP_CMP   = 5'd9,
    OP_CCLR  = 5'd10,
    OP_CSET  = 5'd11,
    OP_CINV  = 5'd12,
    OP_CMOV  = 5'd13,
    OP_CAND  = 5'd14,
    OP_CANDN = 5'd15,
    OP_COR   = 5'd16,
    OP_CORN  = 5'd17
  } op_e;

  typedef struct packed {
    logic c;
    logic ov;
    logic ac;
  } flags_t;

  typedef struct packed {
    logic [WORD_W-1:0] r;
    flags_t            f;
  } arith_t;

  // carry into bit 7 is the carry out of the low seven bits
  function automatic arith_t f_add(input logic [WORD_W-1:0] a,
                                   input logic [WORD_W-1:0] b,
                                   input logic cin);
    arith_t o;
    logic [NIB_W:0]    nib;
    logic [WORD_W-1:0] low7;
    logic [WORD_W:0]   full;
    nib  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    low7 = {1'b0, a[WORD_W-2:0]} + {1'b0, b[WORD_W-2:0]} + {{(WORD_W-1){1'b0}}, cin};
    full = {1'b0, a} + {1'b0, b} + {{WORD_W{1'b0}}, cin};
    o.r    = full[WORD_W-1:0];
    o.f.c  = full[WORD_W];
    o.f.ac = nib[NIB_W];
    o.f.ov = low7[WORD_W-1] ^ full[WORD_W];
    return o;
  endfunction

  function automatic arith_t f_sub(input logic [WORD_W-1:0] a,
                                   input logic [WORD_W-1:0] b,
                                   input logic bin);
    arith_t o;
    logic [NIB_W:0]  nib;
    logic [WORD_W:0] full;
    nib  = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, bin};
    full = {1'b0, a} - {1'b0, b} - {{WORD_W{1'b0}}, bin};
    o.r    = full[WORD_W-1:0];
    o.f.c  = full[WORD_W];
    o.f.ac = nib[NIB_W];
    o.f.ov = (a[WORD_W-1] ^ b[WORD_W-1]) & (full[WORD_W-1] ^ a[WORD_W-1]);
    return o;
  endfunction

  // restoring division, divisor assumed nonzero; returns {remainder, quotient}
  function automatic logic [PROD_W-1:0] f_div(input logic [WORD_W-1:0] n,
                                              input logic [WORD_W-1:0] d);
    logic [WORD_W:0]   rem;
    logic [WORD_W-1:0] q;
    rem = '0;
    q   = n;
    for (int i = 0; i < WORD_W; i++) begin
      rem = {rem[WORD_W-1:0], q[WORD_W-1]};
      q   = {q[WORD_W-2:0], 1'b0};
      if (rem >= {1'b0, d}) begin
        rem  = rem - {1'b0, d};
        q[0] = 1'b1;
      end
    end
    return {rem[WORD_W-1:0], q};
  endfunction

  // decimal adjust; returns {new carry, adjusted byte}
  function automatic logic [WORD_W:0] f_dadj(input logic [WORD_W-1:0] a,
                                             input logic c,
                                             input logic ac);
    logic [WORD_W:0] s1;
    logic [WORD_W:0] s2;
    logic            cc;
    s1 = {1'b0, a} + ((a[NIB_W-1:0] > 4'd9 || ac) ? 9'h006 : 9'h000);
    cc = c | s1[WORD_W];
    s2 = {1'b0, s1[WORD_W-1:0]} +
         ((s1[WORD_W-1:NIB_W] > 4'd9 || cc) ? 9'h060 : 9'h000);
    return {cc | s2[WORD_W], s2[WORD_W-1:0]};
  endfunction
endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
(
  input  op_e               op,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] opnd,
  input  logic [WORD_W-1:0] breg,
  input  flags_t            f_in,
  output logic [WORD_W-1:0] lo,
  output logic [WORD_W-1:0] hi,
  output flags_t            f_nxt,
  output logic              upd_c,
  output logic              upd_ov,
  output logic              upd_ac
);
  arith_t              sum_r;
  arith_t              dif_r;
  logic [PROD_W-1:0]   prod;
  logic [PROD_W-1:0]   quot_rem;
  logic [WORD_W:0]     dadj_r;
  logic                div_zero;

  assign sum_r    = f_add(acc, opnd, (op == OP_ADDC) ? f_in.c : 1'b0);
  assign dif_r    = f_sub(acc, opnd, f_in.c);
  assign prod     = acc * breg;
  assign div_zero = (breg == '0);
  assign quot_rem = div_zero ? '0 : f_div(acc, breg);
  assign dadj_r   = f_dadj(acc, f_in.c, f_in.ac);

  always_comb begin
    lo     = acc;
    hi     = '0;
    f_nxt  = f_in;
    upd_c  = 1'b0;
    upd_ov = 1'b0;
    upd_ac = 1'b0;
    case (op)
      OP_ADD, OP_ADDC: begin
        lo = sum_r.r; f_nxt = sum_r.f;
        upd_c = 1'b1; upd_ov = 1'b1; upd_ac = 1'b1;
      end
      OP_SUBB: begin
        lo = dif_r.r; f_nxt = dif_r.f;
        upd_c = 1'b1; upd_ov = 1'b1; upd_ac = 1'b1;
      end
      OP_MUL: begin
        lo = prod[WORD_W-1:0];
        hi = prod[PROD_W-1:WORD_W];
        f_nxt.c  = 1'b0;
        f_nxt.ov = |prod[PROD_W-1:WORD_W];
        upd_c = 1'b1; upd_ov = 1'b1;
      end
      OP_DIV: begin
        lo = quot_rem[WORD_W-1:0];
        hi = quot_rem[PROD_W-1:WORD_W];
        f_nxt.c  = 1'b0;
        f_nxt.ov = div_zero;
        upd_c = 1'b1; upd_ov = 1'b1;
      end
      OP_DADJ: begin
        lo = dadj_r[WORD_W-1:0];
        f_nxt.c = dadj_r[WORD_W];
        upd_c = 1'b1;
      end
      OP_RRC: begin
        lo = {f_in.c, acc[WORD_W-1:1]};
        f_nxt.c = acc[0];
        upd_c = 1'b1;
      end
      OP_RLC: begin
        lo = {acc[WORD_W-2:0], f_in.c};
        f_nxt.c = acc[WORD_W-1];
        upd_c = 1'b1;
      end
      OP_CMP: begin
        f_nxt.c = (acc < opnd);
        upd_c = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_carry_logic.sv
module alu_carry_logic
  import alu_pkg::*;
(
  input  op_e  op,
  input  logic c_in,
  input  logic bit_op,
  output logic hit,
  output logic c_nxt
);
  always_comb begin
    hit   = 1'b1;
    c_nxt = c_in;
    case (op)
      OP_CCLR:  c_nxt = 1'b0;
      OP_CSET:  c_nxt = 1'b1;
      OP_CINV:  c_nxt = ~c_in;
      OP_CMOV:  c_nxt = bit_op;
      OP_CAND:  c_nxt = c_in & bit_op;
      OP_CANDN: c_nxt = c_in & ~bit_op;
      OP_COR:   c_nxt = c_in | bit_op;
      OP_CORN:  c_nxt = c_in | ~bit_op;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
#(
  parameter int C_POS  = 7,
  parameter int AC_POS = 6,
  parameter int OV_POS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_c,
  input  logic              upd_ov,
  input  logic              upd_ac,
  input  flags_t            alu_f,
  input  logic              wr_byte,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wr_bit,
  input  logic [IDX_W-1:0]  bit_sel,
  input  logic              bit_val,
  output flags_t            flags
);
  localparam logic [IDX_W-1:0] C_IDX  = IDX_W'(C_POS);
  localparam logic [IDX_W-1:0] AC_IDX = IDX_W'(AC_POS);
  localparam logic [IDX_W-1:0] OV_IDX = IDX_W'(OV_POS);

  flags_t nxt;
  logic   unused_wdata;
  assign unused_wdata = ^wdata;

  always_comb begin
    nxt.c  = upd_c  ? alu_f.c  : flags.c;
    nxt.ov = upd_ov ? alu_f.ov : flags.ov;
    nxt.ac = upd_ac ? alu_f.ac : flags.ac;
    if (wr_bit) begin
      if (bit_sel == C_IDX)  nxt.c  = bit_val;
      if (bit_sel == OV_IDX) nxt.ov = bit_val;
      if (bit_sel == AC_IDX) nxt.ac = bit_val;
    end
    if (wr_byte) begin
      nxt.c  = wdata[C_POS];
      nxt.ov = wdata[OV_POS];
      nxt.ac = wdata[AC_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  // R11
  byte_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte |=> (flags.c == $past(wdata[C_POS])) && (flags.ov == $past(wdata[OV_POS]))
                && (flags.ac == $past(wdata[AC_POS])));

  // R12
  bit_wr_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bit && !wr_byte && bit_sel == C_IDX) |=> flags.c == $past(bit_val));

  // R12
  bit_wr_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bit && !wr_byte && bit_sel == OV_IDX) |=> flags.ov == $past(bit_val));
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import alu_pkg::*;
#(
  parameter int C_POS  = 7,
  parameter int AC_POS = 6,
  parameter int OV_POS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [WORD_W-1:0] acc_in,
  input  logic [WORD_W-1:0] opnd_in,
  input  logic [WORD_W-1:0] breg_in,
  input  logic              bit_in,
  input  logic              psw_wr_byte,
  input  logic [WORD_W-1:0] psw_wdata,
  input  logic              psw_wr_bit,
  input  logic [IDX_W-1:0]  psw_bit_sel,
  input  logic              psw_bit_val,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_lo,
  output logic [WORD_W-1:0] res_hi,
  output logic              flag_c,
  output logic              flag_ov,
  output logic              flag_ac
);
  localparam logic [IDX_W-1:0] C_IDX  = IDX_W'(C_POS);
  localparam logic [IDX_W-1:0] AC_IDX = IDX_W'(AC_POS);
  localparam logic [IDX_W-1:0] OV_IDX = IDX_W'(OV_POS);

  op_e               op;
  flags_t            cur_f;
  flags_t            arith_f;
  flags_t            alu_f;
  logic [WORD_W-1:0] arith_lo;
  logic [WORD_W-1:0] arith_hi;
  logic              ar_upd_c, ar_upd_ov, ar_upd_ac;
  logic              bool_hit, bool_c;
  logic              upd_c, upd_ov, upd_ac;
  // named events for the assertions
  logic              c_written, ov_written, ac_written;

  assign op = op_e'(op_sel);

  alu_arith u_arith (
    .op(op), .acc(acc_in), .opnd(opnd_in), .breg(breg_in), .f_in(cur_f),
    .lo(arith_lo), .hi(arith_hi), .f_nxt(arith_f),
    .upd_c(ar_upd_c), .upd_ov(ar_upd_ov), .upd_ac(ar_upd_ac)
  );

  alu_carry_logic u_carry (
    .op(op), .c_in(cur_f.c), .bit_op(bit_in), .hit(bool_hit), .c_nxt(bool_c)
  );

  always_comb begin
    alu_f   = arith_f;
    alu_f.c = bool_hit ? bool_c : arith_f.c;
  end

  assign upd_c  = op_valid & (ar_upd_c | bool_hit);
  assign upd_ov = op_valid & ar_upd_ov;
  assign upd_ac = op_valid & ar_upd_ac;

  assign c_written  = psw_wr_byte | (psw_wr_bit & (psw_bit_sel == C_IDX));
  assign ov_written = psw_wr_byte | (psw_wr_bit & (psw_bit_sel == OV_IDX));
  assign ac_written = psw_wr_byte | (psw_wr_bit & (psw_bit_sel == AC_IDX));

  alu_flag_reg #(.C_POS(C_POS), .AC_POS(AC_POS), .OV_POS(OV_POS)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .upd_c(upd_c), .upd_ov(upd_ov), .upd_ac(upd_ac), .alu_f(alu_f),
    .wr_byte(psw_wr_byte), .wdata(psw_wdata),
    .wr_bit(psw_wr_bit), .bit_sel(psw_bit_sel), .bit_val(psw_bit_val),
    .flags(cur_f)
  );

  assign flag_c  = cur_f.c;
  assign flag_ov = cur_f.ov;
  assign flag_ac = cur_f.ac;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_lo <= arith_lo;
        res_hi <= arith_hi;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);

  // R4 R5
  muldiv_c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == OP_MUL || op_sel == OP_DIV) && !c_written) |=> !flag_c);

  // R10
  ac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(op_valid && (op_sel == OP_ADD || op_sel == OP_ADDC || op_sel == OP_SUBB))
     && !ac_written) |=> flag_ac == $past(flag_ac));

  // R10
  ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_ov && !ov_written) |=> flag_ov == $past(flag_ov));

  // R8
  cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_CMP && !c_written) |=> flag_c == ($past(acc_in) < $past(opnd_in)));

  // R6
  dadj_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_DADJ && flag_c && !c_written) |=> flag_c);
endmodule

// File: tb/acc_alu_flags_test.sv
module acc_alu_flags_test;
  typedef struct {
    logic [7:0] lo;
    logic [7:0] hi;
    bit         chk_res;
    bit         c;
    bit         ov;
    bit         ac;
    string      tag;
  } exp_t;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       op_valid = 0;
  logic [4:0] op_sel = 0;
  logic [7:0] acc_in = 0, opnd_in = 0, breg_in = 0;
  logic       bit_in = 0;
  logic       psw_wr_byte = 0;
  logic [7:0] psw_wdata = 0;
  logic       psw_wr_bit = 0;
  logic [2:0] psw_bit_sel = 0;
  logic       psw_bit_val = 0;
  logic       res_valid;
  logic [7:0] res_lo, res_hi;
  logic       flag_c, flag_ov, flag_ac;

  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  exp_t sb[$];
  bit   mc = 0, mov = 0, mac = 0;

  always #5 clk = ~clk;

  acc_alu_flags uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .breg_in(breg_in), .bit_in(bit_in),
    .psw_wr_byte(psw_wr_byte), .psw_wdata(psw_wdata), .psw_wr_bit(psw_wr_bit),
    .psw_bit_sel(psw_bit_sel), .psw_bit_val(psw_bit_val),
    .res_valid(res_valid), .res_lo(res_lo), .res_hi(res_hi),
    .flag_c(flag_c), .flag_ov(flag_ov), .flag_ac(flag_ac)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // independent model written with integer arithmetic
  task automatic model(input int op, input int a, input int o, input int b, input bit bt,
                       output int lo, output int hi, output bit chk);
    int s, sa, so, v1, v2, t;
    bit c1;
    lo = a; hi = 0; chk = 1;
    sa = (a > 127) ? a - 256 : a;
    so = (o > 127) ? o - 256 : o;
    case (op)
      1, 2: begin
        s = a + o + ((op == 2) ? int'(mc) : 0);
        mac = ((a % 16) + (o % 16) + ((op == 2) ? int'(mc) : 0)) > 15;
        t = sa + so + ((op == 2) ? int'(mc) : 0);
        mov = (t > 127) || (t < -128);
        mc = s > 255; lo = s % 256;
      end
      3: begin
        s = a - o - int'(mc);
        mac = ((a % 16) - (o % 16) - int'(mc)) < 0;
        t = sa - so - int'(mc);
        mov = (t > 127) || (t < -128);
        mc = s < 0; lo = (s + 512) % 256;
      end
      4: begin
        s = a * b; lo = s % 256; hi = s / 256; mc = 0; mov = s > 255;
      end
      5: begin
        mc = 0;
        if (b == 0) begin mov = 1; chk = 0; end
        else begin mov = 0; lo = a / b; hi = a % b; end
      end
      6: begin
        v1 = a + (((a % 16) > 9 || mac) ? 6 : 0);
        c1 = v1 > 255;
        t  = v1 % 256;
        v2 = t + (((t / 16) > 9 || mc || c1) ? 96 : 0);
        mc = mc | c1 | (v2 > 255);
        lo = v2 % 256;
      end
      7: begin lo = (a / 2) + (mc ? 128 : 0); mc = a % 2; end
      8: begin lo = (a * 2) % 256 + int'(mc); mc = a >= 128; end
      9: mc = a < o;
      10: mc = 0;
      11: mc = 1;
      12: mc = !mc;
      13: mc = bt;
      14: mc = mc && bt;
      15: mc = mc && !bt;
      16: mc = mc || bt;
      17: mc = mc || !bt;
      default: ;
    endcase
  endtask

  // driver: one operation with optional direct status writes in the same cycle
  task automatic drive(input string tag, input int op, input int a, input int o,
                       input int b, input bit bt,
                       input bit wb = 0, input int wd = 0,
                       input bit wbit = 0, input int bsel = 0, input bit bval = 0);
    exp_t e;
    int lo, hi;
    bit chk;
    model(op, a, o, b, bt, lo, hi, chk);
    if (wbit) begin
      if (bsel == 7) mc = bval;
      if (bsel == 6) mac = bval;
      if (bsel == 2) mov = bval;
    end
    if (wb) begin
      mc = wd[7]; mac = wd[6]; mov = wd[2];
    end
    e.lo = 8'(lo); e.hi = 8'(hi); e.chk_res = chk;
    e.c = mc; e.ov = mov; e.ac = mac; e.tag = tag;
    @(negedge clk);
    op_valid = 1; op_sel = 5'(op); acc_in = 8'(a); opnd_in = 8'(o);
    breg_in = 8'(b); bit_in = bt;
    psw_wr_byte = wb; psw_wdata = 8'(wd);
    psw_wr_bit = wbit; psw_bit_sel = 3'(bsel); psw_bit_val = bval;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 0; psw_wr_byte = 0; psw_wr_bit = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        check("R1", "unexpected res_valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.chk_res) begin
          check(e.tag, "res_lo", res_lo, e.lo);
          check(e.tag, "res_hi", res_hi, e.hi);
        end
        check(e.tag, "C", flag_c, e.c);
        check(e.tag, "OV", flag_ov, e.ov);
        check(e.tag, "AC", flag_ac, e.ac);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13", "C", flag_c, 0);
    check("R13", "OV", flag_ov, 0);
    check("R13", "AC", flag_ac, 0);
    check("R13", "res_valid", res_valid, 0);
    check("R13", "res_lo", res_lo, 0);
    check("R13", "res_hi", res_hi, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 add patterns
    drive("R2", 1, 8'h3A, 8'hC6, 0, 0);
    drive("R2", 2, 8'h7F, 8'h00, 0, 0);
    drive("R2", 1, 8'h05, 8'h03, 0, 0);
    drive("R2", 2, 8'hFF, 8'hFF, 0, 0);
    // R3 subtract patterns
    drive("R9", 11, 0, 0, 0, 0);
    drive("R3", 3, 8'h10, 8'h01, 0, 0);
    drive("R3", 3, 8'h80, 8'h01, 0, 0);
    drive("R3", 3, 8'h01, 8'h02, 0, 0);
    drive("R3", 3, 8'h7F, 8'hFF, 0, 0);
    // R4 multiply, R10 AC held
    drive("R4", 4, 8'h10, 0, 8'h20, 0);
    drive("R4", 4, 5, 0, 6, 0);
    drive("R4", 4, 8'hFF, 0, 8'hFF, 0);
    // R5 divide and zero divisor
    drive("R5", 5, 8'hFB, 0, 8'h12, 0);
    drive("R5", 5, 7, 0, 9, 0);
    drive("R5", 5, 8'h44, 0, 0, 0);
    drive("R5", 5, 8'hFF, 0, 1, 0);
    // R6 decimal adjust
    drive("R2", 1, 8'h49, 8'h38, 0, 0);
    drive("R6", 6, 8'h81, 0, 0, 0);
    drive("R2", 1, 8'h99, 8'h01, 0, 0);
    drive("R6", 6, 8'h9A, 0, 0, 0);
    drive("R6", 6, 8'h12, 0, 0, 0);
    drive("R9", 10, 0, 0, 0, 0);
    drive("R6", 6, 8'h3C, 0, 0, 0);
    // R7 rotates
    drive("R7", 7, 8'h81, 0, 0, 0);
    drive("R7", 7, 8'h02, 0, 0, 0);
    drive("R7", 8, 8'h80, 0, 0, 0);
    drive("R7", 8, 8'h41, 0, 0, 0);
    // R8 compare
    drive("R8", 9, 8'h10, 8'h20, 0, 0);
    drive("R8", 9, 8'h20, 8'h20, 0, 0);
    drive("R8", 9, 8'hFF, 8'h00, 0, 0);
    // R9 carry logic
    drive("R9", 11, 0, 0, 0, 0);
    drive("R9", 12, 0, 0, 0, 0);
    drive("R9", 13, 8'h5A, 0, 0, 1);
    drive("R9", 15, 0, 0, 0, 1);
    drive("R9", 17, 0, 0, 0, 1);
    drive("R9", 16, 0, 0, 0, 1);
    drive("R9", 14, 0, 0, 0, 0);
    drive("R9", 12, 0, 0, 0, 0);
    drive("R9", 14, 0, 0, 0, 1);
    drive("R9", 15, 0, 0, 0, 0);
    drive("R9", 16, 0, 0, 0, 0);
    drive("R9", 10, 0, 0, 0, 0);
    drive("R9", 17, 0, 0, 0, 0);
    // R1 R10 unknown code and nop leave flags
    drive("R10", 25, 8'h33, 8'hFF, 8'hFF, 1);
    drive("R1", 0, 8'hA5, 0, 0, 0);
    // R11 byte writes, alone and against an operation
    drive("R11", 0, 0, 0, 0, 0, 1, 8'hC4);
    drive("R11", 0, 0, 0, 0, 0, 1, 8'h00);
    drive("R11", 1, 8'hFF, 8'hFF, 0, 0, 1, 8'h00);
    drive("R11", 3, 8'h00, 8'h01, 0, 0, 1, 8'h44, 1, 7, 1);
    // R12 bit writes
    drive("R12", 11, 0, 0, 0, 0, 0, 0, 1, 7, 0);
    drive("R12", 1, 8'hFF, 8'h01, 0, 0, 0, 0, 1, 2, 1);
    drive("R12", 0, 0, 0, 0, 0, 0, 0, 1, 6, 0);
    drive("R12", 0, 0, 0, 0, 0, 0, 0, 1, 3, 1);
    drive("R12", 4, 8'h02, 0, 8'h03, 0, 0, 0, 1, 6, 1);
    // mixed stream
    lf = 8'h5D;
    for (int i = 0; i < 120; i++) begin
      int code;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      code = 1 + (i % 9);
      drive((code <= 2) ? "R2" : (code == 3) ? "R3" : (code == 4) ? "R4" :
            (code == 5) ? "R5" : (code == 6) ? "R6" : (code <= 8) ? "R7" : "R8",
            code, lf, {lf[3:0], lf[7:4]}, lf ^ 8'h3C, lf[2]);
    end
    idle();
    repeat (3) @(negedge clk);
    check("R1", "queue left", sb.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule